// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

A register-mapped calendar clock that advances a BCD timestamp once per second from an external one-cycle tick. The kept fields are seconds, minutes, hours, day of month, month, the year held as two BCD bytes (century and year within the century) and a weekday. Month lengths and leap years follow the Gregorian rules. Software halts the count, loads the fields, then restarts it and polls a status bit until the restart has taken hold.

A 32-bit write bus carries an 8-bit payload in its low byte. Every other bit of the word must hold a fixed key, or the write is discarded. Reads are combinational from the address. A snapshot command copies the live time into shadow storage, and a select bit makes the time addresses return either the copy or the live counters. An alarm compares seven programmed fields against the live time after each second step. It latches a write-one-to-clear pending flag, and a level interrupt is raised while that flag and the alarm enable are both set.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, both year bytes 00, weekday 0. The clock is stopped, every status and enable bit is 0 and `irq` is low.
- R2: On each tick while running, seconds step in BCD. 59 seconds wraps to 00 and carries into minutes, 59 minutes carries into hours, and 23 hours wraps to 00 and carries into the day. A units digit of 9 rolls into the tens digit (09 to 10).
- R3: Control bit 0 (word index 15) is the run request. The running status (word index 17, bit 0) takes the request's value one clock after the write, and ticks advance the time only while this status is 1.
- R4: A day carry past the month's last day returns the day to 01 and advances the month. Months 04, 06, 09 and 11 have 30 days, February has 29 in leap years and 28 otherwise, and the rest have 31. A year is leap when it divides by 4, except century years, which are leap only when the century byte divides by 4. Month 12 wraps to 01 and carries into the year-low byte, and year-low 99 wraps to 00 and carries into year-high.
- R5: The weekday (word index 7, 3 bits) advances with every day carry and wraps from 6 to 0.
- R6: A write is accepted only if bits 31:8 equal 0xC45229. Any other write changes nothing.
- R7: The time fields sit at word indices 0 to 7: seconds, minutes, hours, day, month, year-low, year-high, weekday. They can be written only while the running status is 0, and writes made while it is 1 are dropped.
- R8: Writing control with bit 6 set copies the live time into the shadow. Control bit 7 set makes word indices 0 to 7 read the shadow, and clear makes them read the live time. Control reads back bits 7 and 0, and bit 6 reads as 0.
- R9: The alarm fields sit at word indices 8 to 14, in the time order without the weekday. In the clock after a second step, if the live time equals all seven alarm fields, bit 4 of word index 16 is set. Writing 1 to that bit clears it, and writing 0 leaves it.
- R10: Word index 18 bit 7 is the alarm enable (0xFF arms, 0x00 disarms) and reads back in bit 7. `irq` is high exactly when the pending flag and the enable are both 1.
- R11: Every read returns its field right-aligned in bits 7:0 with all other bits 0, and unmapped indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (8) | Byte address, word index in bits AW-1:2 |
| bus_wdata | input | 32 | Key in 31:8, payload in 7:0 |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level alarm interrupt |

## Verification
A wrong carry or a wrong month-length decision shows on the bus the moment the affected field is read after the offending tick. The bench reads the addressed field every clock, so such an error surfaces within one cycle of the step. A mis-set pending flag or enable shows on `irq` two clocks after the tick that should, or should not, have fired the alarm. A run-status register that fails to lag, or that lets a write in while running, corrupts the loaded time and the status readback in the next cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W = 7;
  localparam int MIN_W = 7;
  localparam int HR_W  = 6;
  localparam int DAY_W = 6;
  localparam int MON_W = 5;
  localparam int YR_W  = 8;
  localparam int WD_W  = 3;
  localparam int NUM_TIME  = 8;
  localparam int NUM_ALARM = 7;
  localparam logic [23:0] WR_KEY = 24'hC45229;
  localparam int IDX_CTL = 15;
  localparam int IDX_IST = 16;
  localparam int IDX_RUN = 17;
  localparam int IDX_IEN = 18;
  localparam int BIT_RUN  = 0;
  localparam int BIT_SNAP = 6;
  localparam int BIT_SEL  = 7;
  localparam int BIT_PEND = 4;
  localparam int BIT_EN   = 7;

  typedef struct packed {
    logic [YR_W-1:0]  yh;
    logic [YR_W-1:0]  yl;
    logic [MON_W-1:0] mon;
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } cal_stamp_t;

  // next BCD value of a two-digit field
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*t + u is a multiple of 4 when 2*t[0] + u is
  function automatic logic bcd_div4(input logic [7:0] v);
    logic [4:0] s;
    s = {3'b000, v[4], 1'b0} + {1'b0, v[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [DAY_W-1:0] month_last(input logic [MON_W-1:0] m,
                                                  input logic [YR_W-1:0] yl,
                                                  input logic [YR_W-1:0] yh);
    logic leap;
    leap = bcd_div4(yl) && ((yl != '0) || bcd_div4(yh));
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_digit_cnt.sv
module cal_digit_cnt #(
  parameter int W = 7,
  parameter logic [W-1:0] FIRST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] last,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic         wrap
);
  import cal_pkg::*;

  logic [W-1:0] q_nxt;
  logic [W-1:0] q_inc;

  assign wrap = step && (q >= last);

  always_comb begin
    q_inc = W'(bcd_next(8'(q)));
    q_nxt = q;
    if (load)      q_nxt = load_val;
    else if (wrap) q_nxt = FIRST;
    else if (step) q_nxt = q_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q <= FIRST;
    else if (load || step) q <= q_nxt;
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [NUM_TIME-1:0] load,
  input  logic [7:0]          load_byte,
  output cal_stamp_t          now,
  output logic [WD_W-1:0]     wday
);
  logic w_sec, w_min, w_hr, w_day, w_mon, w_yl, w_yh, w_wd;
  logic unused_wraps;
  logic [DAY_W-1:0] day_last;

  assign day_last     = month_last(now.mon, now.yl, now.yh);
  assign unused_wraps = w_yh ^ w_wd;

  cal_digit_cnt #(.W(SEC_W), .FIRST('0)) u_sec (
    .clk, .rst_n, .step(step), .load(load[0]), .last(7'h59),
    .load_val(load_byte[SEC_W-1:0]), .q(now.sec), .wrap(w_sec));
  cal_digit_cnt #(.W(MIN_W), .FIRST('0)) u_min (
    .clk, .rst_n, .step(w_sec), .load(load[1]), .last(7'h59),
    .load_val(load_byte[MIN_W-1:0]), .q(now.min), .wrap(w_min));
  cal_digit_cnt #(.W(HR_W), .FIRST('0)) u_hr (
    .clk, .rst_n, .step(w_min), .load(load[2]), .last(6'h23),
    .load_val(load_byte[HR_W-1:0]), .q(now.hr), .wrap(w_hr));
  cal_digit_cnt #(.W(DAY_W), .FIRST(6'h01)) u_day (
    .clk, .rst_n, .step(w_hr), .load(load[3]), .last(day_last),
    .load_val(load_byte[DAY_W-1:0]), .q(now.day), .wrap(w_day));
  cal_digit_cnt #(.W(MON_W), .FIRST(5'h01)) u_mon (
    .clk, .rst_n, .step(w_day), .load(load[4]), .last(5'h12),
    .load_val(load_byte[MON_W-1:0]), .q(now.mon), .wrap(w_mon));
  cal_digit_cnt #(.W(YR_W), .FIRST('0)) u_yl (
    .clk, .rst_n, .step(w_mon), .load(load[5]), .last(8'h99),
    .load_val(load_byte[YR_W-1:0]), .q(now.yl), .wrap(w_yl));
  cal_digit_cnt #(.W(YR_W), .FIRST('0)) u_yh (
    .clk, .rst_n, .step(w_yl), .load(load[6]), .last(8'h99),
    .load_val(load_byte[YR_W-1:0]), .q(now.yh), .wrap(w_yh));
  cal_digit_cnt #(.W(WD_W), .FIRST('0)) u_wd (
    .clk, .rst_n, .step(w_hr), .load(load[7]), .last(3'd6),
    .load_val(load_byte[WD_W-1:0]), .q(wday), .wrap(w_wd));
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_ALARM-1:0] load,
  input  logic [7:0]           load_byte,
  input  logic                 en_we,
  input  logic                 en_val,
  input  logic                 clr_pend,
  input  logic                 check,
  input  cal_stamp_t           now,
  output cal_stamp_t           alm,
  output logic                 armed,
  output logic                 pending
);
  cal_stamp_t alm_nxt;
  logic       armed_nxt;
  logic       pend_nxt;

  always_comb begin
    alm_nxt = alm;
    if (load[0]) alm_nxt.sec = load_byte[SEC_W-1:0];
    if (load[1]) alm_nxt.min = load_byte[MIN_W-1:0];
    if (load[2]) alm_nxt.hr  = load_byte[HR_W-1:0];
    if (load[3]) alm_nxt.day = load_byte[DAY_W-1:0];
    if (load[4]) alm_nxt.mon = load_byte[MON_W-1:0];
    if (load[5]) alm_nxt.yl  = load_byte[YR_W-1:0];
    if (load[6]) alm_nxt.yh  = load_byte[YR_W-1:0];
    armed_nxt = en_we ? en_val : armed;
    pend_nxt  = pending;
    if (check && (now == alm)) pend_nxt = 1'b1;
    else if (clr_pend)         pend_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm     <= '0;
      armed   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (|load) alm   <= alm_nxt;
      if (en_we) armed <= armed_nxt;
      pending <= pend_nxt;
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int IDX_W = AW - 2;

  logic rs_meta, rs_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs_sync, rs_meta} <= 2'b00;
    else        {rs_sync, rs_meta} <= {rs_meta, 1'b1};
  end

  logic [IDX_W-1:0] idx;
  logic             key_ok, wr_ok, ctl_we;
  logic             unused_addr_lsb;
  assign idx             = bus_addr[AW-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign key_ok          = (bus_wdata[31:8] == WR_KEY);
  assign wr_ok           = bus_wr && key_ok;
  assign ctl_we          = wr_ok && (int'(idx) == IDX_CTL);

  logic run_q, running_q, sel_q, tick_d, step;
  logic run_nxt, sel_nxt;
  cal_stamp_t now, shadow_q, shadow_nxt, alm;
  logic [WD_W-1:0] wday, shw_q, shw_nxt;
  logic armed, pending;
  logic [NUM_TIME-1:0]  t_load;
  logic [NUM_ALARM-1:0] a_load;

  assign step = tick_1hz && running_q;

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_tload
    assign t_load[i] = wr_ok && !running_q && (int'(idx) == i);
  end
  for (genvar j = 0; j < NUM_ALARM; j++) begin : g_aload
    assign a_load[j] = wr_ok && (int'(idx) == NUM_TIME + j);
  end

  cal_time_core u_time (
    .clk, .rst_n(rs_sync), .step(step), .load(t_load),
    .load_byte(bus_wdata[7:0]), .now(now), .wday(wday));

  cal_alarm_unit u_alarm (
    .clk, .rst_n(rs_sync), .load(a_load), .load_byte(bus_wdata[7:0]),
    .en_we(wr_ok && (int'(idx) == IDX_IEN)), .en_val(bus_wdata[BIT_EN]),
    .clr_pend(wr_ok && (int'(idx) == IDX_IST) && bus_wdata[BIT_PEND]),
    .check(tick_d), .now(now), .alm(alm), .armed(armed), .pending(pending));

  always_comb begin
    run_nxt    = run_q;
    sel_nxt    = sel_q;
    shadow_nxt = shadow_q;
    shw_nxt    = shw_q;
    if (ctl_we) begin
      run_nxt = bus_wdata[BIT_RUN];
      sel_nxt = bus_wdata[BIT_SEL];
      if (bus_wdata[BIT_SNAP]) begin
        shadow_nxt = now;
        shw_nxt    = wday;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_sync) begin
    if (!rs_sync) begin
      run_q     <= 1'b0;
      running_q <= 1'b0;
      sel_q     <= 1'b0;
      tick_d    <= 1'b0;
      shadow_q  <= '0;
      shw_q     <= '0;
    end else begin
      running_q <= run_q;
      tick_d    <= step;
      if (ctl_we) begin
        run_q    <= run_nxt;
        sel_q    <= sel_nxt;
        shadow_q <= shadow_nxt;
        shw_q    <= shw_nxt;
      end
    end
  end

  cal_stamp_t      view;
  logic [WD_W-1:0] view_wd;
  logic [7:0]      rbyte;

  always_comb begin
    view    = sel_q ? shadow_q : now;
    view_wd = sel_q ? shw_q : wday;
    rbyte   = '0;
    case (int'(idx))
      0:  rbyte = 8'(view.sec);
      1:  rbyte = 8'(view.min);
      2:  rbyte = 8'(view.hr);
      3:  rbyte = 8'(view.day);
      4:  rbyte = 8'(view.mon);
      5:  rbyte = view.yl;
      6:  rbyte = view.yh;
      7:  rbyte = 8'(view_wd);
      8:  rbyte = 8'(alm.sec);
      9:  rbyte = 8'(alm.min);
      10: rbyte = 8'(alm.hr);
      11: rbyte = 8'(alm.day);
      12: rbyte = 8'(alm.mon);
      13: rbyte = alm.yl;
      14: rbyte = alm.yh;
      IDX_CTL: begin rbyte[BIT_SEL] = sel_q; rbyte[BIT_RUN] = run_q; end
      IDX_IST: rbyte[BIT_PEND] = pending;
      IDX_RUN: rbyte[0]        = running_q;
      IDX_IEN: rbyte[BIT_EN]   = armed;
      default: rbyte = '0;
    endcase
  end

  assign bus_rdata = {24'b0, rbyte};
  assign irq       = pending && armed;
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic            clk,
  input logic            rst_ni,
  input logic            bus_wr,
  input logic            key_ok,
  input logic            run_q,
  input logic            running_q,
  input cal_stamp_t      now,
  input logic [WD_W-1:0] wday,
  input logic            irq,
  input logic            armed
);
  // R3: status changes only to the request value of the prior cycle
  a_r3_ack_lag: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(running_q) |-> (running_q == $past(run_q)));

  // R3: no time change while stopped and idle on the bus
  a_r3_frozen_stopped: assert property (@(posedge clk) disable iff (!rst_ni)
    (!running_q && !bus_wr) |=> ($stable(now) && $stable(wday)));

  // R6: a keyless write leaves run request and stopped time alone
  a_r6_key_reject: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && !key_ok && !running_q) |=> ($stable(run_q) && $stable(now)));

  // R10: interrupt only while enabled
  a_r10_irq_armed: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> armed);

  // R2: seconds, minutes, hours stay valid BCD in range
  a_r2_bcd_range: assert property (@(posedge clk) disable iff (!rst_ni)
    (now.sec <= 7'h59) && (now.sec[3:0] <= 4'd9) &&
    (now.min <= 7'h59) && (now.min[3:0] <= 4'd9) && (now.hr <= 6'h23));
endmodule

bind bcd_calendar cal_checker chk_i (
  .clk(clk), .rst_ni(rs_sync), .bus_wr(bus_wr), .key_ok(key_ok),
  .run_q(run_q), .running_q(running_q), .now(now), .wday(wday),
  .irq(irq), .armed(armed));

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq;
  localparam logic [23:0] KEY = 24'hC45229;

  always #5 clk = ~clk;

  bcd_calendar dut_i (.clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  int checks = 0, errors = 0;

  // reference model, binary values
  int m_t[8];
  int m_s[8];
  int m_a[7];
  int msk[8] = '{'h7f, 'h7f, 'h3f, 'h3f, 'h1f, 'hff, 'hff, 'h7};
  bit m_run, m_running, m_sel, m_pend, m_en, m_tickd;

  function automatic int bcd(int v); return (v / 10) * 16 + v % 10; endfunction
  function automatic int unbcd(int b); return (b / 16) * 10 + b % 16; endfunction

  function automatic int dim();
    int y; bit leap;
    y = m_t[6] * 100 + m_t[5];
    leap = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    if (m_t[4] == 2) return leap ? 29 : 28;
    if (m_t[4] == 4 || m_t[4] == 6 || m_t[4] == 9 || m_t[4] == 11) return 30;
    return 31;
  endfunction

  function automatic void adv();
    m_t[0]++; if (m_t[0] < 60) return; m_t[0] = 0;
    m_t[1]++; if (m_t[1] < 60) return; m_t[1] = 0;
    m_t[2]++; if (m_t[2] < 24) return; m_t[2] = 0;
    m_t[7] = (m_t[7] + 1) % 7;
    m_t[3]++; if (m_t[3] <= dim()) return; m_t[3] = 1;
    m_t[4]++; if (m_t[4] <= 12) return; m_t[4] = 1;
    m_t[5]++; if (m_t[5] < 100) return; m_t[5] = 0;
    m_t[6] = (m_t[6] + 1) % 100;
  endfunction

  function automatic int mread(int idx);
    if (idx < 8)  return bcd(m_sel ? m_s[idx] : m_t[idx]);
    if (idx < 15) return bcd(m_a[idx-8]);
    if (idx == 15) return (int'(m_sel) << 7) | int'(m_run);
    if (idx == 16) return int'(m_pend) << 4;
    if (idx == 17) return int'(m_running);
    if (idx == 18) return int'(m_en) << 7;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = '{0, 0, 0, 1, 1, 0, 0, 0};
      m_s = '{default: 0};
      m_a = '{default: 0};
      {m_run, m_running, m_sel, m_pend, m_en, m_tickd} = '0;
    end else begin
      bit ok; int idx; bit match; int old[8];
      ok = wr && (wdata[31:8] == KEY);
      idx = int'(addr[7:2]);
      match = 1'b1;
      for (int k = 0; k < 7; k++) if (m_t[k] != m_a[k]) match = 1'b0;
      if (m_tickd && match) m_pend = 1'b1;
      else if (ok && idx == 16 && wdata[4]) m_pend = 1'b0;
      old = m_t;
      m_tickd = tick && m_running;
      if (ok && idx == 15 && wdata[6]) m_s = old;
      if (tick && m_running) adv();
      else if (ok && idx < 8 && !m_running) m_t[idx] = unbcd(int'(wdata[7:0]) & msk[idx]);
      if (ok && idx >= 8 && idx < 15) m_a[idx-8] = unbcd(int'(wdata[7:0]) & msk[idx-8]);
      if (ok && idx == 18) m_en = wdata[7];
      m_running = m_run;
      if (ok && idx == 15) begin m_run = wdata[0]; m_sel = wdata[7]; end
    end
  end

  // every-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      checks++;
      if (rdata !== 32'(mread(int'(addr[7:2])))) begin
        errors++;
        $display("FAIL R11 reg %0d got %h exp %h", addr[7:2], rdata, mread(int'(addr[7:2])));
      end
      checks++;
      if (irq !== (m_pend && m_en)) begin
        errors++;
        $display("FAIL R10 irq got %b exp %b", irq, m_pend && m_en);
      end
    end
  end

  task automatic wr_reg(int idx, int b, logic [23:0] key = KEY);
    @(negedge clk); wr = 1'b1; addr = 8'(idx * 4); wdata = {key, 8'(b)};
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_now(int idx, int exp, string tag);
    addr = 8'(idx * 4); #1;
    checks++;
    if (rdata[7:0] !== 8'(exp)) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, rdata[7:0], 8'(exp));
    end
  endtask

  task automatic rd_chk(int idx, int exp, string tag);
    @(negedge clk); rd_now(idx, exp, tag);
  endtask

  task automatic chk_irq(bit exp, string tag);
    @(negedge clk); checks++;
    if (irq !== exp) begin errors++; $display("FAIL %s: got %b exp %b", tag, irq, exp); end
  endtask

  task automatic wait_ack(int exp);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); addr = 8'(17 * 4); #1;
      if (rdata[0] == exp[0]) return;
    end
    checks++; errors++;
    $display("FAIL R3 ack timeout got %0d exp %0d", rdata[0], exp);
  endtask

  task automatic secs(int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_time(int yh, int yl, int mo, int d, int h, int mi, int s, int wd);
    wr_reg(15, 0); wait_ack(0);
    wr_reg(0, bcd(s)); wr_reg(1, bcd(mi)); wr_reg(2, bcd(h)); wr_reg(3, bcd(d));
    wr_reg(4, bcd(mo)); wr_reg(5, bcd(yl)); wr_reg(6, bcd(yh)); wr_reg(7, wd);
    wr_reg(15, 1); wait_ack(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd_chk(0, 8'h00, "R1 sec");
    rd_chk(3, 8'h01, "R1 day");
    rd_chk(4, 8'h01, "R1 month");
    rd_chk(6, 8'h00, "R1 year high");
    rd_chk(17, 0, "R1 running");
    chk_irq(1'b0, "R1 irq");
    // R6 bad key
    wr_reg(15, 1, 24'h123456); repeat (2) @(negedge clk);
    rd_now(17, 0, "R6 run ignored");
    wr_reg(0, 8'h33, 24'hC45228);
    rd_chk(0, 8'h00, "R6 sec ignored");
    // load 2000-02-28 23:59:58 weekday 6
    wr_reg(0, 8'h58); wr_reg(1, 8'h59); wr_reg(2, 8'h23); wr_reg(3, 8'h28);
    wr_reg(4, 8'h02); wr_reg(5, 8'h00); wr_reg(6, 8'h20); wr_reg(7, 6);
    rd_chk(0, 8'h58, "R7 loaded while stopped");
    // R3 lag: status still 0 right after the write edge, 1 a clock later
    wr_reg(15, 1);
    rd_now(17, 0, "R3 lag");
    rd_chk(17, 1, "R3 ack");
    secs(1);
    rd_chk(0, 8'h59, "R2 sec step");
    secs(1);
    rd_chk(0, 8'h00, "R2 sec wrap");
    rd_chk(1, 8'h00, "R2 min wrap");
    rd_chk(2, 8'h00, "R2 hour wrap");
    rd_chk(3, 8'h29, "R4 leap feb 29");
    rd_chk(7, 0, "R5 weekday wrap");
    // R7 write while running dropped
    wr_reg(0, 8'h45);
    rd_chk(0, 8'h00, "R7 dropped");
    // R4 century non-leap
    set_time(21, 0, 2, 28, 23, 59, 59, 3);
    secs(1);
    rd_chk(3, 8'h01, "R4 2100 day");
    rd_chk(4, 8'h03, "R4 2100 month");
    rd_chk(7, 4, "R5 weekday step");
    // R4 year carry
    set_time(19, 99, 12, 31, 23, 59, 59, 5);
    secs(1);
    rd_chk(5, 8'h00, "R4 year low wrap");
    rd_chk(6, 8'h20, "R4 year high carry");
    rd_chk(4, 8'h01, "R4 month wrap");
    // R2 digit carry, then R4 30-day month
    set_time(20, 23, 4, 30, 9, 59, 59, 1);
    secs(1);
    rd_chk(2, 8'h10, "R2 hour digit carry");
    set_time(20, 23, 4, 30, 23, 59, 59, 1);
    secs(1);
    rd_chk(3, 8'h01, "R4 april end day");
    rd_chk(4, 8'h05, "R4 april end month");
    // R8 snapshot at 2023-05-01 00:00:00
    wr_reg(15, 8'h41);
    secs(3);
    wr_reg(15, 8'h81);
    rd_chk(15, 8'h81, "R8 ctl readback");
    rd_chk(0, 8'h00, "R8 shadow sec");
    rd_chk(4, 8'h05, "R8 shadow month");
    wr_reg(15, 8'h01);
    rd_chk(0, 8'h03, "R8 live sec");
    // R9 alarm at 00:00:06
    wr_reg(8, 8'h06); wr_reg(9, 0); wr_reg(10, 0); wr_reg(11, 8'h01);
    wr_reg(12, 8'h05); wr_reg(13, 8'h23); wr_reg(14, 8'h20);
    wr_reg(18, 8'hFF);
    rd_chk(18, 8'h80, "R10 enable readback");
    secs(2);
    rd_chk(16, 8'h00, "R9 not yet");
    secs(1);
    rd_chk(16, 8'h10, "R9 pending");
    chk_irq(1'b1, "R10 irq on");
    wr_reg(16, 8'h10);
    rd_chk(16, 8'h00, "R9 w1c clear");
    chk_irq(1'b0, "R10 irq off");
    // R10 disarmed alarm still pends but no irq
    wr_reg(18, 8'h00);
    wr_reg(8, 8'h08);
    secs(2);
    rd_chk(16, 8'h10, "R9 pending disarmed");
    chk_irq(1'b0, "R10 irq masked");
    wr_reg(18, 8'hFF);
    chk_irq(1'b1, "R10 irq armed");
    wr_reg(16, 8'h00);
    rd_chk(16, 8'h10, "R9 write zero keeps");
    wr_reg(16, 8'h10);
    chk_irq(1'b0, "R10 irq cleared");
    rd_chk(20, 8'h00, "R11 unmapped");
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule